// File: doc/BRIEF.md
# Hardware Store Request Controller

This controller sits between a host and a volatile memory array whose contents can be copied into nonvolatile cells. A shared, open-drain request/busy line is split into an input (`req_line_in`) and a drive enable (`req_line_oe`). The drive enable pulls the line low when it is asserted. When the line is seen low, the controller opens a grace window of `TDELAY` clock cycles. During this window array reads still pass and a write already under way may finish. After the window it asks an external copy engine for a store, but only when the array holds unsaved writes.

While the copy engine works, the controller pulls the shared line low as a busy sign and keeps the array closed. When the engine reports completion, the controller releases the line. The array stays closed until the line has been seen high again. Writes are recorded in a dirty flag. A completed store or a recall-done indication from elsewhere clears that flag.

Top module: `hw_store_ctrl`

## Requirements
- R1: In reset, and directly after it, `req_line_oe` and `store_start` are 0. With the line high, `rd_req` and `wr_req` pass straight through to `arr_rd_en` and `arr_wr_en`.
- R2: The line input passes through two synchronising flops. A low level that the controller is not driving itself starts a grace window of exactly `TDELAY` cycles. `store_start` is a one-cycle pulse that appears `TDELAY`+3 rising edges after the edge that first samples the line low.
- R3: A store is started only if a write was accepted since the last store completion or recall completion. A write accepted in the last grace cycle counts. With no such write, `store_start` and `req_line_oe` stay 0. The array stays closed until the line is seen high, and the controller then returns to idle.
- R4: During the grace window, `arr_rd_en` follows `rd_req`.
- R5: A write that was granted in the cycle before stays granted during the grace window for as long as `wr_req` is held. Any write that begins after the request is seen is not passed to `arr_wr_en` until the controller is idle again.
- R6: `req_line_oe` is 1 from the `store_start` cycle up to and including the cycle in which `store_done` is 1. It is 0 in the cycle after that.
- R7: While `req_line_oe` is 1, and after a store until the line is seen high again, both `arr_rd_en` and `arr_wr_en` are 0.
- R8: A `store_done` that ends a store clears the dirty flag, and so does `recall_done`. A write granted in the same cycle as `recall_done` leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_line_in | input | 1 | Level of the shared request/busy line |
| req_line_oe | output | 1 | 1 pulls the shared line low (busy) |
| rd_req | input | 1 | Host read request |
| wr_req | input | 1 | Host write request, held for the length of a write |
| arr_rd_en | output | 1 | Read strobe passed to the array |
| arr_wr_en | output | 1 | Write strobe passed to the array |
| store_start | output | 1 | One-cycle request to the copy engine |
| store_done | input | 1 | Copy engine reports the store finished |
| recall_done | input | 1 | A recall into the array has finished |

## Verification
The bench builds the controller with `TDELAY` set to 5. This keeps the grace window short enough that one scenario can hold a write across the request edge, try a fresh write inside the window, and still measure the exact edge count to `store_start`. The short window also lets several request rounds run back to back. Those rounds cover a clean array, a store followed by a second request, a recall that clears the flag, and a write that coincides with a recall. A long busy phase with the line still held low after completion brings the post-store lockout within reach.

// File: rtl/hw_store_ctrl.sv
module hw_store_ctrl #(
  parameter int TDELAY = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_line_in,
  output logic req_line_oe,
  input  logic rd_req,
  input  logic wr_req,
  output logic arr_rd_en,
  output logic arr_wr_en,
  output logic store_start,
  input  logic store_done,
  input  logic recall_done
);
  localparam int CW = (TDELAY < 2) ? 1 : $clog2(TDELAY);
  localparam logic [CW-1:0] LAST = CW'(TDELAY - 1);

  typedef enum logic [1:0] {S_IDLE, S_GRACE, S_STORE, S_HOLD} st_t;

  st_t          st;
  logic [1:0]   sync;
  logic [CW-1:0] cnt;
  logic         dirty, dirty_nx, wr_act, start_q;

  wire line_hi = sync[1];
  wire req_low = !sync[1] && !req_line_oe;

  assign req_line_oe = (st == S_STORE);
  assign store_start = start_q;
  assign arr_rd_en   = rd_req && (st == S_IDLE || st == S_GRACE);
  assign arr_wr_en   = wr_req && (st == S_IDLE || (st == S_GRACE && wr_act));

  always_comb begin
    dirty_nx = dirty;
    if (arr_wr_en)                                       dirty_nx = 1'b1;
    else if (recall_done || (st == S_STORE && store_done)) dirty_nx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync    <= 2'b11;
      st      <= S_IDLE;
      cnt     <= '0;
      dirty   <= 1'b0;
      wr_act  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      sync    <= {sync[0], req_line_in};
      wr_act  <= arr_wr_en;
      dirty   <= dirty_nx;
      start_q <= 1'b0;
      case (st)
        S_IDLE: if (req_low) begin
          st  <= S_GRACE;
          cnt <= '0;
        end
        S_GRACE: begin
          if (cnt == LAST) begin
            if (dirty_nx) begin
              st      <= S_STORE;
              start_q <= 1'b1;
            end else begin
              st <= S_HOLD;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_STORE: if (store_done) st <= S_HOLD;
        default: if (line_hi) st <= S_IDLE;
      endcase
    end
  end

  a_r7_busy_closes_array: assert property (@(posedge clk) disable iff (!rst_n)
    req_line_oe |-> (!arr_wr_en && !arr_rd_en));

  a_r6_start_drives_busy: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |-> req_line_oe);

  a_r3_start_needs_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |-> dirty);

  a_r6_busy_held_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (req_line_oe && !store_done) |=> req_line_oe);

  a_r7_closed_after_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_line_oe) |-> (!arr_wr_en && !arr_rd_en));

  a_r5_no_fresh_write: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && !$past(arr_wr_en)) |-> !arr_wr_en);

  a_r2_start_is_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    store_start |=> !store_start);
endmodule

// File: tb/tb_hw_store_ctrl.sv
module tb_hw_store_ctrl;
  localparam int TD = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_low = 1'b0;
  logic rd_req = 1'b0, wr_req = 1'b0, store_done = 1'b0, recall_done = 1'b0;
  logic req_line_oe, arr_rd_en, arr_wr_en, store_start;
  wire  line = !(host_low || req_line_oe);

  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  hw_store_ctrl #(.TDELAY(TD)) dut (
    .clk(clk), .rst_n(rst_n), .req_line_in(line), .req_line_oe(req_line_oe),
    .rd_req(rd_req), .wr_req(wr_req), .arr_rd_en(arr_rd_en), .arr_wr_en(arr_wr_en),
    .store_start(store_start), .store_done(store_done), .recall_done(recall_done));

  // behavioural reference: 0 idle, 1 grace, 2 busy, 3 locked
  int m_st = 0, m_cnt = 0;
  bit m_s1 = 1, m_s2 = 1, m_dirty = 0, m_wact = 0, m_start = 0;

  function automatic bit m_we();
    return wr_req && (m_st == 0 || (m_st == 1 && m_wact));
  endfunction
  function automatic bit m_re();
    return rd_req && (m_st <= 1);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st <= 0; m_cnt <= 0; m_s1 <= 1; m_s2 <= 1;
      m_dirty <= 0; m_wact <= 0; m_start <= 0;
    end else begin
      automatic bit we = m_we();
      automatic bit dn = we ? 1'b1 : ((recall_done || (m_st == 2 && store_done)) ? 1'b0 : m_dirty);
      m_s1 <= line; m_s2 <= m_s1; m_wact <= we; m_dirty <= dn; m_start <= 0;
      if (m_st == 0 && !m_s2 && m_st != 2) begin m_st <= 1; m_cnt <= 0; end
      else if (m_st == 1) begin
        if (m_cnt == TD - 1) begin
          if (dn) begin m_st <= 2; m_start <= 1; end else m_st <= 3;
        end else m_cnt <= m_cnt + 1;
      end
      else if (m_st == 2 && store_done) m_st <= 3;
      else if (m_st == 3 && m_s1 == m_s1 && m_s2) m_st <= 0;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    #1;
    check(arr_rd_en == m_re(), "R4 arr_rd_en vs model", arr_rd_en, m_re());
    check(arr_wr_en == m_we(), "R5 arr_wr_en vs model", arr_wr_en, m_we());
    check(req_line_oe == (m_st == 2), "R6 req_line_oe vs model", req_line_oe, m_st == 2);
    check(store_start == m_start, "R2/R3 store_start vs model", store_start, m_start);
    @(negedge clk);
  endtask

  task automatic request_round(output bit started);
    started = 0;
    host_low = 1;
    for (int i = 0; i < TD + 6; i++) begin
      tick();
      if (store_start) started = 1;
    end
    if (req_line_oe) begin
      store_done = 1; tick(); store_done = 0;
    end
    host_low = 0;
    repeat (4) tick();
  endtask

  initial begin
    bit st;
    int n;
    repeat (3) @(negedge clk);
    #1;
    check(req_line_oe == 0, "R1 busy in reset", req_line_oe, 0);
    check(store_start == 0, "R1 start in reset", store_start, 0);
    rst_n = 1;
    @(negedge clk);
    rd_req = 1; wr_req = 0;
    #1;
    check(arr_rd_en == 1, "R1 read passes when idle", arr_rd_en, 1);
    @(negedge clk);

    // clean array: request yields no store, array locked until line high
    host_low = 1;
    st = 0;
    for (int i = 0; i < TD + 6; i++) begin
      tick();
      if (i == 2) check(arr_rd_en == 1, "R4 read during grace", arr_rd_en, 1);
      if (store_start || req_line_oe) st = 1;
    end
    check(st == 0, "R3 no store when clean", st, 0);
    check(arr_rd_en == 0, "R3 locked while line low", arr_rd_en, 0);
    host_low = 0;
    repeat (3) tick();
    check(arr_rd_en == 1, "R3 idle after line high", arr_rd_en, 1);

    // dirty array, write held across the request
    rd_req = 0;
    wr_req = 1; tick(); wr_req = 0; tick();
    wr_req = 1; host_low = 1;
    n = 0;
    repeat (4) begin tick(); n++; end
    check(arr_wr_en == 1, "R5 in-flight write continues", arr_wr_en, 1);
    wr_req = 0; tick(); n++;
    wr_req = 1; rd_req = 1; tick(); n++;
    check(arr_wr_en == 0, "R5 fresh write blocked", arr_wr_en, 0);
    check(arr_rd_en == 1, "R4 read during grace", arr_rd_en, 1);
    while (!store_start && n < 40) begin tick(); n++; end
    check(n == TD + 3, "R2 edges to store_start", n, TD + 3);
    check(req_line_oe == 1, "R6 busy at start", req_line_oe, 1);
    check(arr_rd_en == 0 && arr_wr_en == 0, "R7 array closed while busy", arr_rd_en, 0);
    repeat (6) tick();
    check(req_line_oe == 1, "R6 busy held", req_line_oe, 1);
    store_done = 1; tick(); store_done = 0;
    check(req_line_oe == 0, "R6 released after done", req_line_oe, 0);
    check(arr_rd_en == 0 && arr_wr_en == 0, "R7 closed after release", arr_wr_en, 0);
    repeat (5) tick();
    check(arr_rd_en == 0, "R7 still closed while line low", arr_rd_en, 0);
    host_low = 0; wr_req = 0;
    repeat (3) tick();
    check(arr_rd_en == 1, "R7 reopened after line high", arr_rd_en, 1);
    rd_req = 0;

    request_round(st);
    check(st == 0, "R8 store clears dirty", st, 0);

    wr_req = 1; tick(); wr_req = 0; tick();
    recall_done = 1; tick(); recall_done = 0;
    request_round(st);
    check(st == 0, "R8 recall clears dirty", st, 0);

    wr_req = 1; recall_done = 1; tick(); wr_req = 0; recall_done = 0; tick();
    request_round(st);
    check(st == 1, "R8 write wins over recall", st, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule